// File: doc/BRIEF.md
# Multi-mode timer/event counter

This block is an 8-bit up-counter with a preload register and a control register, both reached over a small register bus. The control register picks one of three counting sources: edges on an external input (the polarity is selectable), a power-of-two division of the system clock, or that divided clock gated by a pulse on the external input so the counter measures how long the pulse lasts. The external input passes through a two-stage synchronizer before edge detection.

When the count steps past 0xFF, the counter reloads from the preload register. It also raises a one-cycle interrupt request if the interrupt enable input is high, and it flips a toggle output that can drive a buzzer. A write to the count address updates the preload register. It updates the counter as well only while counting is stopped. A read of the count address suppresses any count step in that cycle.

Top module: `pulse_event_timer`

## Requirements
- R1: After reset the counter, preload, control register, interrupt request and toggle output are all 0.
- R2: Address 1 reads back the control register as written, with bit 5 always reading 0.
- R3: In timer mode (bits 7:6 = 10) with run bit 4 set, the counter steps once every 2^n clocks, where n is control bits 2:0.
- R4: In event mode (bits 7:6 = 01) with bit 4 set, the counter steps once per synchronized edge of the external input: rising when bit 3 is 0, falling when bit 3 is 1.
- R5: With mode bits 7:6 = 00 the counter never steps.
- R6: A step from 0xFF reloads the counter from the preload register and flips the toggle output.
- R7: The interrupt request is high for exactly the cycle after each reload step when the interrupt enable is 1, and it stays low when the enable is 0.
- R8: In pulse mode (bits 7:6 = 11) with bit 4 set, a selected-polarity edge starts a measurement. The divided clock is counted until the opposite edge, which clears bit 4. Further edges then have no effect until bit 4 is written to 1 again. In timer and event modes bit 4 never clears by itself.
- R9: A write to address 0 while bit 4 is 0 loads both counter and preload. While bit 4 is 1, the same write changes only the preload.
- R10: A cycle with a read strobe at address 0 performs no count step.
- R11: A preload write in the same cycle as a reload step makes the counter take the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 1 | Register select: 0 count/preload, 1 control |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register |
| extIn | input | 1 | External event or pulse input, asynchronous |
| irqEnable | input | 1 | Interrupt enable |
| irqReq | output | 1 | One-cycle interrupt request |
| toneOut | output | 1 | Toggle output, flips on every reload |

## Verification
Two pairs of events can fall in the same clock cycle. A count step can meet a read of the counter. A reload step can meet a preload write. The bench provokes the first by issuing read strobes while the timer steps every clock. The cycle model drops the step in each read cycle, and the counter value read back afterwards must match it. The bench provokes the second by starting the timer at 0xFF and writing a new preload in the very next cycle. The counter read after that must show the new value plus the one further step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmrMode_t;

  typedef struct packed {
    logic step;
    logic preWrite;
    logic cntWrite;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PSC_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [PSC_W+3:0] ctrlWrData,
  input  logic             extIn,
  output logic [PSC_W+4:0] ctrlQ,
  output logic             runBit,
  output tmrMode_t         modeQ,
  output tmrStrobe_t       strobes
);
  localparam int DIV_W = (1 << PSC_W) - 1;
  localparam int EDGE_POS = PSC_W;
  localparam int RUN_POS = PSC_W + 1;

  logic [PSC_W-1:0] pscQ;
  logic edgeQ, runQ, measQ, extPrev;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [DIV_W-1:0] divQ, divMask;
  logic tick, extS, rise, fall, actEdge, endEdge, rawStep, pulseDone, ctrlWrite;

  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else syncQ <= {syncQ[SYNC_STAGES-2:0], extIn};
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else syncQ <= extIn;
    end
  endgenerate

  assign extS = syncQ[SYNC_STAGES-1];
  assign rise = extS && !extPrev;
  assign fall = !extS && extPrev;
  assign actEdge = edgeQ ? fall : rise;
  assign endEdge = edgeQ ? rise : fall;

  assign divMask = DIV_W'(({{DIV_W{1'b0}}, 1'b1} << pscQ) - 1'b1);
  assign tick = (divQ & divMask) == divMask;

  assign ctrlWrite = regWrEn && regAddr;
  assign pulseDone = runQ && (modeQ == MODE_PULSE) && measQ && endEdge;

  always_comb begin
    unique case (modeQ)
      MODE_EVENT: rawStep = runQ && actEdge;
      MODE_TIMER: rawStep = runQ && tick;
      MODE_PULSE: rawStep = runQ && measQ && tick;
      default:    rawStep = 1'b0;
    endcase
  end

  assign strobes.step = rawStep && !(regRdEn && !regAddr);
  assign strobes.preWrite = regWrEn && !regAddr;
  assign strobes.cntWrite = regWrEn && !regAddr && !runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      divQ <= '0;
      pscQ <= '0;
      edgeQ <= 1'b0;
      runQ <= 1'b0;
      modeQ <= MODE_OFF;
      measQ <= 1'b0;
    end else begin
      extPrev <= extS;
      divQ <= divQ + 1'b1;
      if (!runQ || modeQ != MODE_PULSE) measQ <= 1'b0;
      else if (!measQ && actEdge) measQ <= 1'b1;
      else if (measQ && endEdge) measQ <= 1'b0;
      if (ctrlWrite) begin
        pscQ <= ctrlWrData[PSC_W-1:0];
        edgeQ <= ctrlWrData[EDGE_POS];
        runQ <= ctrlWrData[RUN_POS];
        modeQ <= tmrMode_t'(ctrlWrData[PSC_W+3:PSC_W+2]);
      end else if (pulseDone) begin
        runQ <= 1'b0;
      end
    end
  end

  assign ctrlQ = {modeQ, 1'b0, runQ, edgeQ, pscQ};
  assign runBit = runQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] countQ,
  output logic              ovfPulse,
  output logic              irqReq,
  output logic              toneOut
);
  logic [DATA_W-1:0] preQ, reloadVal;

  assign ovfPulse = strobes.step && (countQ == {DATA_W{1'b1}});
  assign reloadVal = strobes.preWrite ? wrData : preQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      preQ <= '0;
      irqReq <= 1'b0;
      toneOut <= 1'b0;
    end else begin
      if (strobes.preWrite) preQ <= wrData;
      if (strobes.cntWrite) countQ <= wrData;
      else if (strobes.step) countQ <= ovfPulse ? reloadVal : countQ + DATA_W'(1);
      irqReq <= ovfPulse && irqEnable;
      toneOut <= toneOut ^ ovfPulse;
    end
  end
endmodule

// File: rtl/pulse_event_timer.sv
module pulse_event_timer
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       extIn,
  input  logic       irqEnable,
  output logic       irqReq,
  output logic       toneOut
);
  localparam int DATA_W = 8;
  localparam int PSC_W = 3;

  tmrStrobe_t strobes;
  tmrMode_t modeQ;
  logic [DATA_W-1:0] ctrlQ, countNow;
  logic runBit, ovfPulse;

  tmr_ctrl #(.PSC_W(PSC_W), .SYNC_STAGES(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .ctrlWrData({regWrData[7:6], regWrData[4:0]}), .extIn(extIn),
    .ctrlQ(ctrlQ), .runBit(runBit), .modeQ(modeQ), .strobes(strobes)
  );

  tmr_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData), .irqEnable(irqEnable),
    .countQ(countNow), .ovfPulse(ovfPulse), .irqReq(irqReq), .toneOut(toneOut)
  );

  assign regRdData = regAddr ? ctrlQ : countNow;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       irqReq,
  input logic       irqEnable,
  input logic       toneOut,
  input logic       ovfPulse,
  input logic       runBit,
  input logic [1:0] modeBits,
  input logic       regWrEn,
  input logic       regAddr,
  input logic       regRdEn,
  input logic [7:0] countNow
);
  assert_tone_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    (toneOut != $past(toneOut)) |-> $past(ovfPulse));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(ovfPulse && irqEnable));

  assert_run_selfclear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runBit) |-> ($past(regWrEn && regAddr) || $past(modeBits == 2'b11)));

  assert_mode_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == 2'b00 && !(regWrEn && !regAddr)) |=> $stable(countNow));

  assert_read_block_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regAddr && !(regWrEn && !regAddr)) |=> $stable(countNow));
endmodule

bind pulse_event_timer tmr_checker chk_i (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEnable(irqEnable), .toneOut(toneOut),
  .ovfPulse(ovfPulse), .runBit(runBit), .modeBits(modeQ), .regWrEn(regWrEn),
  .regAddr(regAddr), .regRdEn(regRdEn), .countNow(countNow)
);

// File: tb/pulse_event_timer_tb.sv
`timescale 1ns/1ps
module pulse_event_timer_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic regAddr = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0, extIn = 1'b0, irqEnable = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic irqReq, toneOut;
  int checks = 0, failures = 0;
  bit done = 0;

  pulse_event_timer dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .extIn(extIn),
    .irqEnable(irqEnable), .irqReq(irqReq), .toneOut(toneOut)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model, one update per rising edge
  logic [7:0] mCnt = 0, mPre = 0, mCtrl = 0;
  bit mMeas = 0, mTone = 0, mIrq = 0, s1 = 0, s2 = 0, prev = 0;
  int pc = 0;

  always @(posedge clk) begin : model
    int div, mode;
    bit run, tick, act, opp, step, ovf, wrCnt, wrCtl, doneP;
    logic [7:0] nCnt;
    if (!rstN) begin
      mCnt = 0; mPre = 0; mCtrl = 0; mMeas = 0; mTone = 0; mIrq = 0;
      s1 = 0; s2 = 0; prev = 0; pc = 0;
    end else begin
      div = 1 << (mCtrl & 7);
      mode = mCtrl >> 6;
      run = mCtrl[4];
      tick = (pc % div) == (div - 1);
      act = mCtrl[3] ? (!s2 && prev) : (s2 && !prev);
      opp = mCtrl[3] ? (s2 && !prev) : (!s2 && prev);
      case (mode)
        1: step = run && act;
        2: step = run && tick;
        3: step = run && mMeas && tick;
        default: step = 0;
      endcase
      if (regRdEn && !regAddr) step = 0;
      ovf = step && mCnt == 8'hFF;
      wrCnt = regWrEn && !regAddr;
      wrCtl = regWrEn && regAddr;
      doneP = run && mode == 3 && mMeas && opp;
      nCnt = mCnt;
      if (wrCnt && !run) nCnt = regWrData;
      else if (step) nCnt = ovf ? (wrCnt ? regWrData : mPre) : mCnt + 8'd1;
      if (!run || mode != 3) mMeas = 0;
      else if (!mMeas && act) mMeas = 1;
      else if (mMeas && opp) mMeas = 0;
      if (wrCtl) mCtrl = regWrData & 8'hDF;
      else if (doneP) mCtrl[4] = 0;
      if (wrCnt) mPre = regWrData;
      mCnt = nCnt;
      mIrq = ovf && irqEnable;
      mTone = mTone ^ ovf;
      prev = s2; s2 = s1; s1 = extIn;
      pc = (pc + 1) % 128;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of interrupt and toggle outputs
  always @(negedge clk) if (rstN && !done) begin
    check(irqReq == mIrq, "R7 irq vs model", irqReq, mIrq);
    check(toneOut == mTone, "R6 tone vs model", toneOut, mTone);
  end

  // tasks start and end at a falling edge
  task automatic writeReg(input bit a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic readReg(input bit a, input string tag, input int lit);
    int expv;
    regAddr = a; regRdEn = 1;
    #1;
    expv = a ? mCtrl : mCnt;
    check(regRdData == expv, tag, regRdData, expv);
    if (lit >= 0) check(regRdData == lit, tag, regRdData, lit);
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(irqReq == 0 && toneOut == 0, "R1 outputs after reset", {irqReq, toneOut}, 0);
    readReg(0, "R1 counter after reset", 0);
    readReg(1, "R1 control after reset", 0);
    // R2 control readback, bit 5 forced low
    writeReg(1, 8'hFF);
    readReg(1, "R2 control readback", 8'hDF);
    writeReg(1, 8'h00);
    // R9 stopped write loads counter
    writeReg(0, 8'h10);
    readReg(0, "R9 stopped write", 8'h10);
    // R5 mode off with run set
    writeReg(1, 8'h10);
    idle(20);
    readReg(0, "R5 mode off no count", 8'h10);
    // R9 running write touches only preload
    writeReg(0, 8'hF0);
    readReg(0, "R9 running write", 8'h10);
    // R3 R6 R7 timer divide by 1 with interrupts
    writeReg(1, 8'h00);
    writeReg(0, 8'hF0);
    irqEnable = 1;
    writeReg(1, 8'h90);
    idle(40);
    readReg(0, "R3 timer n=0", -1);
    // R3 divide by 8
    writeReg(1, 8'h93);
    idle(60);
    readReg(0, "R3 timer n=3", -1);
    readReg(1, "R8 timer keeps run bit", 8'h93);
    // R7 interrupt disabled across overflows
    irqEnable = 0;
    writeReg(1, 8'h90);
    idle(40);
    irqEnable = 1;
    // R10 reads back to back while stepping every clock
    writeReg(1, 8'h00);
    writeReg(0, 8'h20);
    writeReg(1, 8'h90);
    for (int i = 0; i < 6; i++) readReg(0, "R10 read blocks step", -1);
    // R4 event mode rising edges through overflow
    writeReg(1, 8'h00);
    writeReg(0, 8'hFD);
    writeReg(1, 8'h50);
    for (int i = 0; i < 4; i++) begin
      extIn = 1; idle(3); extIn = 0; idle(3);
    end
    idle(3);
    readReg(0, "R4 rising edges", 8'hFE);
    // R4 falling edges
    writeReg(1, 8'h00);
    writeReg(0, 8'h00);
    writeReg(1, 8'h58);
    for (int i = 0; i < 3; i++) begin
      extIn = 1; idle(4); extIn = 0; idle(2);
    end
    idle(3);
    readReg(0, "R4 falling edges", 8'h03);
    readReg(1, "R8 event keeps run bit", 8'h58);
    // R11 preload write on the reload cycle
    writeReg(1, 8'h00);
    writeReg(0, 8'hFF);
    writeReg(1, 8'h90);
    writeReg(0, 8'h33);
    writeReg(1, 8'h00);
    readReg(0, "R11 reload takes new preload", 8'h34);
    // R8 pulse width measurement
    writeReg(0, 8'h00);
    writeReg(1, 8'hD0);
    idle(5);
    readReg(0, "R8 armed no count", 8'h00);
    extIn = 1; idle(10); extIn = 0;
    idle(6);
    readReg(0, "R8 pulse width", 8'd10);
    readReg(1, "R8 run self-cleared", 8'hC0);
    extIn = 1; idle(5); extIn = 0; idle(5);
    readReg(0, "R8 no re-arm", 8'd10);
    idle(2);
    finishRun();
  end
endmodule